// File: doc/BRIEF.md
# Deferred Checksum Enable Guard

A transmitter can begin sending a frame before the host has finished filling the transmit buffer. That frame starts with its trailing checksum held back. When the host has written its last byte, it issues a cancel command, and the frame may then close with a valid checksum. This block makes that choice at frame end. The frame-end logic then appends either a good or a deliberately corrupted checksum. The checksum itself is computed elsewhere.

While a frame is in flight, the block compares every host buffer write against the region the transmitter has already read. That region runs from the configured start offset up to, but not including, the transmitter's read pointer, and it may wrap around the end of a ring buffer. A write into that region arrives too late to be sent. After such a write the block refuses any cancel, forces a bad checksum and sets a sticky error flag. The host clears the flag by writing one to it.

Top module: `txbuf_fcs_guard`

## Requirements
- R1: After reset, `fcs_good`, `fcs_valid`, `buf_err` and `cancel_pend` are all 0.
- R2: A frame started with `sup_req`=0 and with no late write ends with `fcs_good`=1.
- R3: A frame started with `sup_req`=1 that receives no cancel ends with `fcs_good`=0, and `buf_err` stays 0.
- R4: A frame started with `sup_req`=1 that receives a cancel and no late write ends with `fcs_good`=1.
- R5: A host write during an active frame to an address in the consumed region is a late write, whether it comes before or after a cancel and whether or not the frame was suppressed. The frame then ends with `fcs_good`=0, and `buf_err` goes to 1 on the cycle after the write.
- R6: A write at or above `rd_ptr`, a write below `start_ofs` (when not wrapped), and any write made while no frame is active are not late. They set no error and do not change the checksum decision.
- R7: `cancel_req` sets `cancel_pend` on the next cycle. The block consumes it one cycle later, and `cancel_pend` returns to 0.
- R8: If `rd_ptr` < `start_ofs`, the consumed region wraps: an address is late when addr >= `start_ofs` or addr < `rd_ptr`. If `rd_ptr` == `start_ofs`, nothing is consumed.
- R9: `frame_start` clears the late-write and cancel state of the previous frame. `buf_err` is unaffected and stays 1 until an `err_clr` pulse.
- R10: `fcs_valid` pulses for exactly one cycle, on the cycle after `frame_end` is sampled while a frame is active. `fcs_good` changes only with that pulse, and `frame_end` with no active frame does nothing.
- R11: If a late write and `err_clr` arrive in the same cycle, `buf_err` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse: a new frame begins |
| sup_req | input | 1 | Checksum suppression requested for the frame being started |
| frame_end | input | 1 | Pulse: the last payload byte has been sent |
| cancel_req | input | 1 | Pulse: host sets the cancel-suppression command |
| host_wr_en | input | 1 | Host buffer write strobe |
| host_wr_addr | input | ADDR_W | Host buffer write address |
| start_ofs | input | ADDR_W | Buffer offset at which the frame data starts |
| rd_ptr | input | ADDR_W | Next address the transmitter will read |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| cancel_pend | output | 1 | Cancel command waiting to be acted on (self-clearing) |
| fcs_good | output | 1 | 1 = append a valid checksum, 0 = append a bad one |
| fcs_valid | output | 1 | One-cycle strobe: `fcs_good` holds this frame's decision |
| buf_err | output | 1 | Sticky late-write error flag |

## Verification
The hardest case is a frame that has received a cancel and is then hit by a late write, so that the error must override a cancel already accepted. A second hard case is a wrapped read pointer whose consumed region spans the top and bottom of the buffer. The bench drives `rd_ptr` and `start_ofs` directly, so it can place any consumed region, including an empty or wrapped one. The bench can also choose the order of the cancel and the write within a frame. It aims writes at both edges of the region, and it also pulses `err_clr` in the same cycle as a late write.

// File: rtl/txg_pkg.sv
package txg_pkg;

    localparam int DEF_ADDR_W = 10;

    // Per-frame decision state
    typedef struct packed {
        logic active;   // frame in flight
        logic sup;      // checksum suppressed at start
        logic canc;     // suppression cancelled (accepted)
        logic late;     // late write seen this frame
        logic cbit;     // cancel command pending
        logic good;     // last decision
        logic valid;    // decision strobe
    } txg_frame_t;

    typedef struct packed {
        logic err;
    } txg_stat_t;

endpackage

// File: rtl/txg_late_detect.sv
module txg_late_detect #(
    parameter int ADDR_W   = txg_pkg::DEF_ADDR_W,
    parameter bit RING_BUF = 1'b1
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] start_ofs,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic              in_consumed
);

    logic ge_start;
    logic lt_rd;

    assign ge_start = (wr_addr >= start_ofs);
    assign lt_rd    = (wr_addr <  rd_ptr);

    generate
        if (RING_BUF) begin : g_ring
            // Consumed span may wrap past the top of the buffer
            logic wrapped;
            assign wrapped     = (rd_ptr < start_ofs);
            assign in_consumed = wrapped ? (ge_start | lt_rd) : (ge_start & lt_rd);
        end else begin : g_linear
            assign in_consumed = ge_start & lt_rd;
        end
    endgenerate

endmodule

// File: rtl/txg_frame_ctrl.sv
module txg_frame_ctrl
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic sup_req,
    input  logic frame_end,
    input  logic cancel_req,
    input  logic wr_hit,
    output logic late_evt,
    output logic cancel_pend,
    output logic fcs_good,
    output logic fcs_valid
);

    txg_frame_t st_d, st_q;
    logic       canc_eff;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        late_evt   = st_q.active & wr_hit & ~frame_start;
        canc_eff   = st_q.canc | (st_q.cbit & ~st_q.late & ~late_evt);

        // consume a pending cancel command
        if (st_q.cbit) begin
            st_d.cbit = 1'b0;
            if (st_q.active && !st_q.late && !late_evt) begin
                st_d.canc = 1'b1;
            end
        end
        if (cancel_req) begin
            st_d.cbit = 1'b1;
        end

        // late write overrides any cancel
        if (late_evt) begin
            st_d.late = 1'b1;
            st_d.canc = 1'b0;
        end

        if (frame_start) begin
            st_d.active = 1'b1;
            st_d.sup    = sup_req;
            st_d.canc   = 1'b0;
            st_d.late   = 1'b0;
        end else if (frame_end && st_q.active) begin
            st_d.active = 1'b0;
            st_d.valid  = 1'b1;
            st_d.good   = (~st_q.sup | canc_eff) & ~st_q.late & ~late_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cancel_pend = st_q.cbit;
    assign fcs_good    = st_q.good;
    assign fcs_valid   = st_q.valid;

endmodule

// File: rtl/txg_status.sv
module txg_status
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic late_evt,
    input  logic err_clr,
    output logic buf_err
);

    txg_stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (err_clr) begin
            stat_d.err = 1'b0;
        end
        if (late_evt) begin
            stat_d.err = 1'b1;   // set wins over clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign buf_err = stat_q.err;

endmodule

// File: rtl/txbuf_fcs_guard.sv
module txbuf_fcs_guard #(
    parameter int ADDR_W   = txg_pkg::DEF_ADDR_W,
    parameter bit RING_BUF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sup_req,
    input  logic              frame_end,
    input  logic              cancel_req,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [ADDR_W-1:0] start_ofs,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic              err_clr,
    output logic              cancel_pend,
    output logic              fcs_good,
    output logic              fcs_valid,
    output logic              buf_err
);

    logic in_consumed;
    logic wr_hit;
    logic late_evt;

    txg_late_detect #(
        .ADDR_W   (ADDR_W),
        .RING_BUF (RING_BUF)
    ) u_detect (
        .wr_addr     (host_wr_addr),
        .start_ofs   (start_ofs),
        .rd_ptr      (rd_ptr),
        .in_consumed (in_consumed)
    );

    assign wr_hit = host_wr_en & in_consumed;

    txg_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .sup_req     (sup_req),
        .frame_end   (frame_end),
        .cancel_req  (cancel_req),
        .wr_hit      (wr_hit),
        .late_evt    (late_evt),
        .cancel_pend (cancel_pend),
        .fcs_good    (fcs_good),
        .fcs_valid   (fcs_valid)
    );

    txg_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .late_evt (late_evt),
        .err_clr  (err_clr),
        .buf_err  (buf_err)
    );

endmodule

// File: rtl/txbuf_fcs_guard_chk.sv
module txbuf_fcs_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_end,
    input logic cancel_req,
    input logic host_wr_en,
    input logic err_clr,
    input logic cancel_pend,
    input logic fcs_good,
    input logic fcs_valid,
    input logic buf_err
);

    // R7: pending cancel is consumed after one cycle
    p_cancel_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_pend && !cancel_req |=> !cancel_pend);

    // R9: error flag is sticky until cleared
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_err && !err_clr |=> buf_err);

    // R5: error only rises after a host write
    p_err_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_err) |-> $past(host_wr_en));

    // R10: decision strobe follows a frame end
    p_valid_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_valid |-> $past(frame_end));

    // R10: strobe lasts one cycle
    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_valid |=> !fcs_valid);

    // R10: decision holds between strobes
    p_good_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fcs_valid |-> $stable(fcs_good));

endmodule

bind txbuf_fcs_guard txbuf_fcs_guard_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_end   (frame_end),
    .cancel_req  (cancel_req),
    .host_wr_en  (host_wr_en),
    .err_clr     (err_clr),
    .cancel_pend (cancel_pend),
    .fcs_good    (fcs_good),
    .fcs_valid   (fcs_valid),
    .buf_err     (buf_err)
);

// File: tb/test_txbuf_fcs_guard.sv
`timescale 1ns/1ps
module test_txbuf_fcs_guard;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0, sup_req = 1'b0, frame_end = 1'b0;
    logic          cancel_req = 1'b0, host_wr_en = 1'b0, err_clr = 1'b0;
    logic [AW-1:0] host_wr_addr = '0, start_ofs = '0, rd_ptr = '0;
    logic          cancel_pend, fcs_good, fcs_valid, buf_err;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    txbuf_fcs_guard #(.ADDR_W(AW), .RING_BUF(1'b1)) i_txbuf_fcs_guard (
        .clk, .rst_n, .frame_start, .sup_req, .frame_end, .cancel_req,
        .host_wr_en, .host_wr_addr, .start_ofs, .rd_ptr, .err_clr,
        .cancel_pend, .fcs_good, .fcs_valid, .buf_err
    );

    typedef struct packed {
        logic          sup;
        logic          canc;
        logic          wr;
        logic [AW-1:0] addr;
        logic [AW-1:0] start;
        logic [AW-1:0] rd;
        logic          exp_good;
        logic          exp_err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 10'd0,    10'd0,   10'd0,  1'b1, 1'b0}, // R2
        '{1'b1, 1'b0, 1'b0, 10'd0,    10'd0,   10'd0,  1'b0, 1'b0}, // R3
        '{1'b1, 1'b1, 1'b0, 10'd0,    10'd0,   10'd0,  1'b1, 1'b0}, // R4
        '{1'b1, 1'b1, 1'b1, 10'd20,   10'd16,  10'd40, 1'b0, 1'b1}, // R5
        '{1'b1, 1'b1, 1'b1, 10'd40,   10'd16,  10'd40, 1'b1, 1'b0}, // R6 at rd_ptr
        '{1'b1, 1'b1, 1'b1, 10'd15,   10'd16,  10'd40, 1'b1, 1'b0}, // R6 below start
        '{1'b1, 1'b1, 1'b1, 10'd16,   10'd16,  10'd40, 1'b0, 1'b1}, // R5 at start
        '{1'b1, 1'b1, 1'b1, 10'd1000, 10'd900, 10'd50, 1'b0, 1'b1}, // R8 upper
        '{1'b1, 1'b1, 1'b1, 10'd5,    10'd900, 10'd50, 1'b0, 1'b1}, // R8 lower
        '{1'b1, 1'b1, 1'b1, 10'd60,   10'd900, 10'd50, 1'b1, 1'b0}, // R8 gap
        '{1'b1, 1'b1, 1'b1, 10'd300,  10'd300, 10'd300,1'b1, 1'b0}, // R8 empty
        '{1'b0, 1'b0, 1'b1, 10'd20,   10'd16,  10'd40, 1'b0, 1'b1}  // R5 unsuppressed
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nclk();
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; nclk(); err_clr = 1'b0;
    endtask

    // Runs one frame; outputs are sampled on the negedge after frame_end.
    task automatic run_frame(input logic sup, input logic canc, input logic wr,
                             input logic [AW-1:0] addr, input logic [AW-1:0] st,
                             input logic [AW-1:0] rd, input logic canc_first);
        frame_start = 1'b1; sup_req = sup; start_ofs = st; rd_ptr = rd;
        nclk();
        frame_start = 1'b0;
        if (canc_first) begin
            cancel_req = canc; nclk(); cancel_req = 1'b0; nclk();
            host_wr_en = wr; host_wr_addr = addr; nclk(); host_wr_en = 1'b0;
        end else begin
            host_wr_en = wr; host_wr_addr = addr; nclk(); host_wr_en = 1'b0;
            cancel_req = canc; nclk(); cancel_req = 1'b0;
        end
        nclk();
        frame_end = 1'b1; nclk(); frame_end = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        nclk(); nclk();
        // R1 reset state
        check("R1 fcs_good", fcs_good, 0);
        check("R1 fcs_valid", fcs_valid, 0);
        check("R1 buf_err", buf_err, 0);
        check("R1 cancel_pend", cancel_pend, 0);
        rst_n = 1'b1;
        nclk();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            pulse_clr();
            run_frame(VECS[i].sup, VECS[i].canc, VECS[i].wr, VECS[i].addr,
                      VECS[i].start, VECS[i].rd, 1'b0);
            check($sformatf("R10 vec%0d valid", i), fcs_valid, 1);
            check($sformatf("R2-5,8 vec%0d good", i), fcs_good, VECS[i].exp_good);
            check($sformatf("R5/R6 vec%0d err", i), buf_err, VECS[i].exp_err);
            nclk();
            check($sformatf("R10 vec%0d single", i), fcs_valid, 0);
        end

        // R5: cancel accepted first, late write afterwards still forces bad
        pulse_clr();
        run_frame(1'b1, 1'b1, 1'b1, 10'd20, 10'd16, 10'd40, 1'b1);
        check("R5 cancel-then-late good", fcs_good, 0);
        check("R5 cancel-then-late err", buf_err, 1);

        // R9: next frame starts clean, error persists
        run_frame(1'b1, 1'b1, 1'b0, 10'd0, 10'd16, 10'd40, 1'b0);
        check("R9 late state reset", fcs_good, 1);
        check("R9 err sticky", buf_err, 1);
        pulse_clr();
        check("R9 err cleared", buf_err, 0);

        // R7: cancel self-clear
        cancel_req = 1'b1; nclk(); cancel_req = 1'b0;
        check("R7 cancel set", cancel_pend, 1);
        nclk();
        check("R7 cancel cleared", cancel_pend, 0);

        // R6: write into consumed range with no frame active
        host_wr_en = 1'b1; host_wr_addr = 10'd20; start_ofs = 10'd16; rd_ptr = 10'd40;
        nclk(); host_wr_en = 1'b0;
        check("R6 idle write err", buf_err, 0);

        // R10: frame_end with no active frame
        frame_end = 1'b1; nclk(); frame_end = 1'b0;
        check("R10 idle end valid", fcs_valid, 0);
        check("R10 idle end good held", fcs_good, 1);

        // R11: late write and clear in the same cycle
        frame_start = 1'b1; sup_req = 1'b1; nclk(); frame_start = 1'b0;
        host_wr_en = 1'b1; host_wr_addr = 10'd30; err_clr = 1'b1;
        nclk(); host_wr_en = 1'b0; err_clr = 1'b0;
        check("R11 set wins", buf_err, 1);
        frame_end = 1'b1; nclk(); frame_end = 1'b0;
        check("R11 frame bad", fcs_good, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule